// File: doc/BRIEF.md
# Grouped Prescaler Tick Generator

This block turns one free-running clock into five independent single-cycle tick enables, one per timer channel. Two 8-bit prescalers do the coarse division. Each prescaler serves a fixed group of channels: channels 0 and 1 share one prescaler, and channels 2, 3 and 4 share the other. Each channel then applies its own divider, whose ratio is a power of two selected by a 4-bit field. Downstream counters advance only in the cycles where their tick is high.

Software sets up the block through two configuration words on a small register bus. A write has one cycle of latency, and a read returns data in the same cycle. Each write to a configuration word restarts every prescaler and every divider at once. As a result, the first tick after a change is always a complete period at the new ratio, never a stretched or shortened one. With a 24 MHz clock, a channel ticks at 24 MHz / ((prescale + 1) * 2^select).

Top module: `tickgen_top`

## Requirements
- R1: While reset is held and right after it, the prescale word (address 0) reads 0x0101, the select word (address 1) reads 0, and all ticks are low. Reset release acts as a restart with these values.
- R2: A write to address 0 stores wdata[15:0] and a write to address 1 stores wdata[19:0]. Reads from either address return the stored value, zero-extended to 32 bits.
- R3: Bits [7:0] of the prescale word set the prescaler of channels 0 and 1. Bits [15:8] set the prescaler of channels 2, 3 and 4.
- R4: The divider select of channel c sits in bits [4c+3:4c] of the select word. Its ratio is 2 raised to the field value.
- R5: A channel whose prescaler value is P and whose select value is S gives a tick that is high for one cycle, every (P+1)*2^S cycles. When that product is 1, the tick stays high in every cycle.
- R6: A write to address 0 or 1 restarts all channels. In the cycle after the write edge, every tick is low, including a tick that was due at that edge. The first tick of channel c then comes exactly (P+1)*2^S cycles after the write edge, using the new values.
- R7: Select values up to 15 are honoured in full: with P=0 and S=15, the tick period is 32768 cycles.
- R8: Channels that share a prescaler and hold the same select value tick in the same cycles.
- R9: A write to address 2 or 3 changes no register and does not restart any channel. A read from address 2 or 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that is divided down |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tick | output | 5 | One tick-enable strobe per channel |

## Verification
The checker watches several properties on every cycle. Every tick must follow a strobe from its own group's prescaler. Ticks go quiet after any mapped write. Writes must land in the configuration words, and unmapped writes must leave them unchanged. A tick with a nonzero select must last only one cycle. Channels with matching settings in the same group must tick in lockstep. Exact periods, first-tick distances after reset and after a restart in mid-period, the full 15-step divider, and the absence of a restart on an unmapped write all depend on absolute cycle numbers. Only the bench's scenarios show these: the bench predicts every tick cycle of every channel and compares it with what the design produces.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;
    // channel and group organisation
    localparam int TG_NUM_CH    = 5;
    localparam int TG_GRP0_SIZE = 2;   // channels below this index use prescaler 0
    localparam int TG_NUM_GRP   = 2;
    // field widths
    localparam int TG_PRE_W     = 8;
    localparam int TG_SEL_W     = 4;
    // register bus
    localparam int TG_DATA_W    = 32;
    localparam int TG_ADDR_W    = 2;
    // derived
    localparam int TG_PRE_BITS  = TG_NUM_GRP * TG_PRE_W;
    localparam int TG_SEL_BITS  = TG_NUM_CH * TG_SEL_W;
    localparam int TG_DIV_W     = (1 << TG_SEL_W) - 1;

    function automatic int tg_group_of(input int ch);
        return (ch < TG_GRP0_SIZE) ? 0 : 1;
    endfunction
endpackage

// File: rtl/tickgen_regs.sv
module tickgen_regs #(
    parameter int PRE_W   = tickgen_pkg::TG_PRE_W,
    parameter int SEL_W   = tickgen_pkg::TG_SEL_W,
    parameter int NUM_GRP = tickgen_pkg::TG_NUM_GRP,
    parameter int NUM_CH  = tickgen_pkg::TG_NUM_CH,
    parameter int DATA_W  = tickgen_pkg::TG_DATA_W,
    parameter int ADDR_W  = tickgen_pkg::TG_ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_GRP*PRE_W-1:0]   pre_q_o,
    output logic [NUM_GRP*PRE_W-1:0]   pre_d_o,
    output logic [NUM_CH*SEL_W-1:0]    sel_q_o,
    output logic                       restart_o
);
    localparam int PRE_BITS = NUM_GRP * PRE_W;
    localparam int SEL_BITS = NUM_CH * SEL_W;
    localparam logic [ADDR_W-1:0] ADDR_PRE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_SEL = ADDR_W'(1);
    localparam logic [PRE_W-1:0]  PRE_RST  = PRE_W'(1);

    typedef struct packed {
        logic [PRE_BITS-1:0] pre;
        logic [SEL_BITS-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic hit_pre, hit_sel;

    always_comb begin
        cfg_d   = cfg_q;
        hit_pre = wr_en && (addr == ADDR_PRE);
        hit_sel = wr_en && (addr == ADDR_SEL);
        if (hit_pre) cfg_d.pre = wdata[PRE_BITS-1:0];
        if (hit_sel) cfg_d.sel = wdata[SEL_BITS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.pre <= {NUM_GRP{PRE_RST}};
            cfg_q.sel <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_PRE) rdata[PRE_BITS-1:0] = cfg_q.pre;
        if (addr == ADDR_SEL) rdata[SEL_BITS-1:0] = cfg_q.sel;
    end

    assign pre_q_o   = cfg_q.pre;
    assign pre_d_o   = cfg_d.pre;
    assign sel_q_o   = cfg_q.sel;
    assign restart_o = hit_pre || hit_sel;
endmodule

// File: rtl/tickgen_prescaler.sv
module tickgen_prescaler #(
    parameter int PRE_W = tickgen_pkg::TG_PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] load_val,   // value in force after this edge
    input  logic [PRE_W-1:0] reload_val, // value in force now
    output logic             strobe
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = reload_val;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.cnt <= PRE_W'(1);
        else        st_q     <= st_d;
    end

    assign strobe = (st_q.cnt == '0);
endmodule

// File: rtl/tickgen_divider.sv
module tickgen_divider #(
    parameter int SEL_W = tickgen_pkg::TG_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             strobe,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [DIV_W-1:0] limit;

    // limit = 2^sel - 1 as a mask of low ones
    always_comb begin
        for (int b = 0; b < DIV_W; b++) begin
            limit[b] = (b < int'(sel));
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (strobe) begin
            if (st_q.cnt == limit) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/tickgen_top.sv
module tickgen_top #(
    parameter int NUM_CH    = tickgen_pkg::TG_NUM_CH,
    parameter int GRP0_SIZE = tickgen_pkg::TG_GRP0_SIZE,
    parameter int PRE_W     = tickgen_pkg::TG_PRE_W,
    parameter int SEL_W     = tickgen_pkg::TG_SEL_W,
    parameter int DATA_W    = tickgen_pkg::TG_DATA_W,
    parameter int ADDR_W    = tickgen_pkg::TG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] tick
);
    localparam int NUM_GRP  = 2;
    localparam int PRE_BITS = NUM_GRP * PRE_W;
    localparam int SEL_BITS = NUM_CH * SEL_W;

    logic [PRE_BITS-1:0] pre_q, pre_d;
    logic [SEL_BITS-1:0] sel_q;
    logic                restart;
    logic [NUM_GRP-1:0]  grp_strobe;

    tickgen_regs #(
        .PRE_W(PRE_W), .SEL_W(SEL_W), .NUM_GRP(NUM_GRP),
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pre_q_o(pre_q), .pre_d_o(pre_d),
        .sel_q_o(sel_q), .restart_o(restart)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
        tickgen_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .restart(restart),
            .load_val(pre_d[g*PRE_W +: PRE_W]),
            .reload_val(pre_q[g*PRE_W +: PRE_W]),
            .strobe(grp_strobe[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < GRP0_SIZE) ? 0 : 1;
        tickgen_divider #(.SEL_W(SEL_W)) u_div (
            .clk(clk), .rst_n(rst_n), .restart(restart),
            .strobe(grp_strobe[GRP]),
            .sel(sel_q[c*SEL_W +: SEL_W]),
            .tick(tick[c])
        );
    end
endmodule

// File: rtl/tickgen_chk.sv
module tickgen_chk #(
    parameter int NUM_CH    = tickgen_pkg::TG_NUM_CH,
    parameter int GRP0_SIZE = tickgen_pkg::TG_GRP0_SIZE,
    parameter int PRE_W     = tickgen_pkg::TG_PRE_W,
    parameter int SEL_W     = tickgen_pkg::TG_SEL_W,
    parameter int DATA_W    = tickgen_pkg::TG_DATA_W,
    parameter int ADDR_W    = tickgen_pkg::TG_ADDR_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [DATA_W-1:0]        wdata,
    input logic [NUM_CH-1:0]        tick,
    input logic [1:0]               grp_strobe,
    input logic [2*PRE_W-1:0]       pre_cfg,
    input logic [NUM_CH*SEL_W-1:0]  sel_cfg
);
    localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> tick == '0);

    // R2
    pre_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PRE) |=> pre_cfg == $past(wdata[2*PRE_W-1:0]));

    // R2
    sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SEL) |=> sel_cfg == $past(wdata[NUM_CH*SEL_W-1:0]));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != A_PRE && addr != A_SEL) |=> ($stable(pre_cfg) && $stable(sel_cfg)));

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_PRE || addr == A_SEL)) |=> tick == '0);

    // R8
    lockstep_g0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cfg[0 +: SEL_W] == sel_cfg[SEL_W +: SEL_W]) |-> tick[0] == tick[1]);

    // R8
    lockstep_g1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_cfg[2*SEL_W +: SEL_W] == sel_cfg[3*SEL_W +: SEL_W]) |-> tick[2] == tick[3]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < GRP0_SIZE) ? 0 : 1;

        // R3
        group_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick[c] |-> $past(grp_strobe[GRP]));

        // R5
        single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[c] && sel_cfg[c*SEL_W +: SEL_W] != '0) |=> !tick[c]);
    end
endmodule

bind tickgen_top tickgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tick(tick), .grp_strobe(grp_strobe), .pre_cfg(pre_q), .sel_cfg(sel_q)
);

// File: tb/sim_tickgen_top.sv
module sim_tickgen_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  tick;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    mon_on = 1'b0;
    int    exp_q[NCH][$];
    string cur_req = "R5";
    logic [31:0] cur_pre = 32'h0101;
    logic [31:0] cur_sel = 32'h0;
    int    win_w = 0;

    tickgen_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // push every expected tick cycle in (base, stop]
    task automatic expect_ticks(input int base, input int stop);
        for (int c = 0; c < NCH; c++) begin
            int p = (c < 2) ? int'(cur_pre[7:0]) : int'(cur_pre[15:8]);
            int s = int'(cur_sel[4*c +: 4]);
            int n = (p + 1) << s;
            for (int t = base + n; t <= stop; t += n) exp_q[c].push_back(t);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on) begin
            for (int c = 0; c < NCH; c++) begin
                if (tick[c]) begin
                    checks++;
                    if (exp_q[c].size() == 0) begin
                        errors++;
                        $display("FAIL %s ch%0d unexpected tick: actual cycle %0d expected none", cur_req, c, cyc);
                    end else if (exp_q[c][0] != cyc) begin
                        errors++;
                        $display("FAIL %s ch%0d tick: actual cycle %0d expected %0d", cur_req, c, cyc, exp_q[c][0]);
                        if (exp_q[c][0] < cyc) void'(exp_q[c].pop_front());
                    end else begin
                        void'(exp_q[c].pop_front());
                    end
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // load both words; win_w becomes the cycle of the last write edge
    task automatic program_cfg(input logic [31:0] pre, input logic [31:0] sel, input string req);
        mon_on = 1'b0;
        for (int c = 0; c < NCH; c++) exp_q[c].delete();
        bus_write(2'd0, pre);
        bus_write(2'd1, sel);
        win_w   = cyc;
        cur_pre = pre & 32'hFFFF;
        cur_sel = sel & 32'hFFFFF;
        cur_req = req;
        // R6: all ticks low right after the restarting write
        check_eq("R6", "ticks after write", tick, 0);
    endtask

    // run L cycles; optionally issue one write at step 'at'
    task automatic run_window(input int len, input int at, input logic [1:0] wa, input logic [31:0] wd);
        expect_ticks(win_w, win_w + len);
        mon_on = 1'b1;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (i == at) begin
                wr_en = 1'b1; addr = wa; wdata = wd;
                if (wa == 2'd0 || wa == 2'd1) begin
                    if (wa == 2'd0) cur_pre = wd & 32'hFFFF;
                    else            cur_sel = wd & 32'hFFFFF;
                    for (int c = 0; c < NCH; c++) exp_q[c].delete();
                    expect_ticks(win_w + at + 1, win_w + len);
                end
            end
        end
        wr_en = 1'b0;
        #1;
        for (int c = 0; c < NCH; c++) begin
            check_eq(cur_req, $sformatf("ch%0d missed ticks", c), exp_q[c].size(), 0);
            exp_q[c].delete();
        end
        mon_on = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        addr = 2'd0; #1;
        check_eq("R1", "prescale word in reset", rdata, 32'h0101);
        addr = 2'd1; #1;
        check_eq("R1", "select word in reset", rdata, 32'h0);
        check_eq("R1", "ticks in reset", tick, 0);
        @(negedge clk);
        rst_n = 1'b1;
        win_w = cyc;
        cur_req = "R1";
        run_window(40, 0, 2'd0, 32'h0);

        // R2, R3, R4: distinct ratios per group and channel
        program_cfg(32'hFFFF_0302, 32'hFFF1_2010, "R4");
        addr = 2'd0; #1;
        check_eq("R2", "prescale readback", rdata, 32'h0302);
        addr = 2'd1; #1;
        check_eq("R2", "select readback", rdata, 32'h0001_2010);
        run_window(100, 0, 2'd0, 32'h0);

        // R5: period of one cycle keeps tick high
        program_cfg(32'h0, 32'h0, "R5");
        run_window(20, 0, 2'd0, 32'h0);

        // R3: large prescale on group 0, small on group 1
        program_cfg(32'h04FF, 32'h10302, "R3");
        run_window(2100, 0, 2'd0, 32'h0);

        // R7 and R8: full divider select on all channels
        program_cfg(32'h0, 32'hFFFFF, "R7");
        run_window(33000, 0, 2'd0, 32'h0);

        // R6: prescale rewrite at the edge where a tick was due
        program_cfg(32'h0303, 32'h0, "R6");
        run_window(30, 7, 2'd0, 32'h0101);

        // R6: select-only rewrite restarts too
        program_cfg(32'h0, 32'h22222, "R6");
        run_window(20, 3, 2'd1, 32'h00001);

        // R9: unmapped write leaves ratios and phase alone
        program_cfg(32'h0, 32'h11111, "R9");
        run_window(20, 5, 2'd2, 32'h0);
        addr = 2'd2; #1;
        check_eq("R9", "read of address 2", rdata, 0);
        addr = 2'd3; #1;
        check_eq("R9", "read of address 3", rdata, 0);
        addr = 2'd0; #1;
        check_eq("R9", "prescale after unmapped write", rdata, 32'h0);
        addr = 2'd1; #1;
        check_eq("R9", "select after unmapped write", rdata, 32'h11111);

        report();
    end
endmodule